// File: doc/BRIEF.md
# Block-merging scan data decompressor

This block expands a compressed serial stream of scan test data into the bit stream that feeds a scan chain. The compressed stream begins with a short header that selects the block length. After the header comes a sequence of codewords. Each codeword says how many consecutive copies of one block to produce. It also says whether that block is sent literally or is a block of all zeros or all ones.

A tester presents one encoded bit at a time with a valid flag. The decompressor raises its ready output whenever it can take a bit. While it is replaying a block it holds ready low and produces one scan bit per clock. Literal bits pass straight to the scan output as they arrive and are captured at the same time for replay. A start pulse marks the beginning of a new test set, and a header is read only after that pulse.

Top module: `bm_decomp`

## Requirements
- R1: While reset is high and in the first cycle after it, the block sits in its idle state with `in_ready` and `out_valid` low.
- R2: In the idle state no encoded bit is taken (`in_ready` low) and no output appears. A `start` pulse in any state moves the block to header reading, discarding any partly read codeword.
- R3: The header is the first 3 bits after `start`, most significant bit first. The block length is the header value plus 4 (000 gives 4, 110 gives 10), and header 111 is treated as length 10.
- R4: A codeword whose first bit is 0 carries one block: the next b bits are emitted unchanged, in arrival order, each on `out_bit` with `out_valid` high in the cycle after it is taken.
- R5: A codeword starting 1 then 0 produces two copies. It is followed by a type bit: 0 means b literal bits follow, and 1 means a fill block whose value is the next bit.
- R6: A codeword starting with k ones (k from 2 to 5), then a 0 when k is below 5, carries a k-bit count, most significant bit first. It yields (2^k - 1) + count copies, so 3 to 62. The type bit and the fill bit or literal bits follow, as in R5.
- R7: A fill block produces copies x b bits of the fill value. The first of them appears in the cycle after the fill bit is taken.
- R8: After the last literal bit of a multi-copy block, the remaining copies follow back to back at one bit per clock with `in_ready` low, so the whole expansion is contiguous when the tester never stalls.
- R9: An encoded bit is consumed only in a cycle where `in_ready` and `in_valid` are both high. A cycle with `in_ready` high and `in_valid` low yields no output in the next cycle and does not change the result.
- R10: When a codeword's expansion ends, the next bit is read as the first bit of a new codeword with no new header.
- R11: With header 001, the stream 110 01 0 10111, 10 1 0, 0 11000 expands to four copies of 10111, then ten zeros, then 11000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new test set (header follows) |
| in_bit | input | 1 | Encoded serial data bit |
| in_valid | input | 1 | Encoded bit is present |
| in_ready | output | 1 | Decompressor can take an encoded bit this cycle |
| out_bit | output | 1 | Expanded scan data bit |
| out_valid | output | 1 | `out_bit` carries a scan bit this cycle |

## Verification
Every cycle, the assertions check the handshake and sequencing rules. They check that ready stays low while a block is being replayed and that each replay cycle yields an output bit. They check that a literal bit taken from the tester reappears on the output one cycle later, and that an idle cycle produces nothing. They also check that start always leads to header reading and that the idle state holds without it. Only the bench scenarios can show the decoded content: the header-to-length mapping, the prefix and count arithmetic over all groups up to 62 copies, the fill values and the order of replayed bits. The bench compares these against an independently built expansion of each random and directed stream, including stalls from the tester.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PFX,
    ST_CNT,
    ST_TYPE,
    ST_FILLV,
    ST_LIT,
    ST_EMIT
  } bm_state_e;

  typedef enum logic [1:0] {
    SRC_IN,
    SRC_FILL,
    SRC_BLK
  } bm_src_e;

endpackage

// File: rtl/bm_blk_store.sv
module bm_blk_store #(
  parameter int MAX_BLK = 10,
  localparam int IDX_W = $clog2(MAX_BLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             in_bit,
  input  logic             fill_ld,
  input  bm_pkg::bm_src_e  src,
  output logic             data_o
);
  import bm_pkg::*;

  // block storage written by index, no reset so it maps onto plain memory
  logic blk_mem [MAX_BLK];
  logic fill_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_mem[idx] <= in_bit;
    end
  end

  // fill value latch (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= 1'b0;
    end else if (fill_ld) begin
      fill_q <= in_bit;
    end
  end

  always_comb begin
    unique case (src)
      SRC_FILL: data_o = fill_q;
      SRC_BLK:  data_o = blk_mem[idx];
      default:  data_o = in_bit;
    endcase
  end

endmodule

// File: rtl/bm_out_stage.sv
module bm_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic emit_en,
  input  logic emit_bit,
  output logic out_bit,
  output logic out_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= emit_en;
      out_bit   <= emit_en ? emit_bit : 1'b0;
    end
  end

endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl #(
  parameter int MIN_BLK  = 4,
  parameter int MAX_BLK  = 10,
  parameter int HDR_W    = 3,
  parameter int MAX_ONES = 5,
  localparam int IDX_W  = $clog2(MAX_BLK),
  localparam int LEN_W  = $clog2(MAX_BLK + 1),
  localparam int TOT_W  = MAX_ONES + 1,
  localparam int ONES_W = $clog2(MAX_ONES + 1),
  localparam int HCNT_W = $clog2(HDR_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                in_bit,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                emit_en,
  output bm_pkg::bm_src_e     emit_src,
  output logic                wr_en,
  output logic                fill_ld,
  output logic [IDX_W-1:0]    idx_o,
  output bm_pkg::bm_state_e   state_o
);
  import bm_pkg::*;

  bm_state_e           state_q;
  logic [HCNT_W-1:0]   hdr_cnt_q;
  logic [HDR_W-1:0]    hdr_sr_q;
  logic [LEN_W-1:0]    len_q;
  logic [ONES_W-1:0]   ones_q;
  logic [ONES_W-1:0]   fld_left_q;
  logic [MAX_ONES-1:0] fld_q;
  logic [TOT_W-1:0]    tot_q;
  logic [IDX_W-1:0]    idx_q;
  logic                fill_mode_q;

  logic                accept;
  logic                last_idx;
  logic [HDR_W-1:0]    hdr_next;
  logic [MAX_ONES-1:0] fld_next;
  logic [TOT_W-1:0]    base_w;
  logic [TOT_W-1:0]    tot_from_fld;

  // header value to block length, saturating at the largest length (R3)
  function automatic logic [LEN_W-1:0] size_of(input logic [HDR_W-1:0] h);
    int v;
    v = int'(h) + MIN_BLK;
    if (v > MAX_BLK) v = MAX_BLK;
    return LEN_W'(v);
  endfunction

  always_comb begin
    in_ready = (state_q == ST_HDR)  || (state_q == ST_PFX)   ||
               (state_q == ST_CNT)  || (state_q == ST_TYPE)  ||
               (state_q == ST_FILLV) || (state_q == ST_LIT);
  end

  assign accept   = in_ready && in_valid && !start;
  assign last_idx = (idx_q == IDX_W'(len_q - LEN_W'(1)));
  assign hdr_next = {hdr_sr_q[HDR_W-2:0], in_bit};
  assign fld_next = {fld_q[MAX_ONES-2:0], in_bit};

  // prefix ones read as a binary number: k ones -> 2^k - 1 (R6)
  always_comb begin
    base_w = '0;
    for (int i = 0; i < MAX_ONES; i++) begin
      if (ONES_W'(i) < ones_q) base_w[i] = 1'b1;
    end
    tot_from_fld = base_w + {1'b0, fld_next};
  end

  always_comb begin
    emit_en  = 1'b0;
    emit_src = SRC_IN;
    wr_en    = 1'b0;
    fill_ld  = 1'b0;
    if (!start) begin
      if (state_q == ST_EMIT) begin
        emit_en  = 1'b1;
        emit_src = fill_mode_q ? SRC_FILL : SRC_BLK;
      end else if (accept && state_q == ST_LIT) begin
        emit_en = 1'b1;
        wr_en   = 1'b1;
      end else if (accept && state_q == ST_FILLV) begin
        emit_en = 1'b1;
        fill_ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hdr_cnt_q   <= '0;
      hdr_sr_q    <= '0;
      len_q       <= LEN_W'(MIN_BLK);
      ones_q      <= '0;
      fld_left_q  <= '0;
      fld_q       <= '0;
      tot_q       <= '0;
      idx_q       <= '0;
      fill_mode_q <= 1'b0;
    end else if (start) begin
      // R2: restart at the header from any state
      state_q   <= ST_HDR;
      hdr_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_HDR: if (accept) begin
          hdr_sr_q  <= hdr_next;
          hdr_cnt_q <= hdr_cnt_q + HCNT_W'(1);
          if (hdr_cnt_q == HCNT_W'(HDR_W - 1)) begin
            len_q   <= size_of(hdr_next);
            ones_q  <= '0;
            state_q <= ST_PFX;
          end
        end
        ST_PFX: if (accept) begin
          if (in_bit) begin
            ones_q <= ones_q + ONES_W'(1);
            if (ones_q == ONES_W'(MAX_ONES - 1)) begin
              // longest prefix has no closing zero
              fld_left_q <= ONES_W'(MAX_ONES);
              fld_q      <= '0;
              state_q    <= ST_CNT;
            end
          end else if (ones_q == '0) begin
            tot_q   <= TOT_W'(1);
            idx_q   <= '0;
            state_q <= ST_LIT;
          end else if (ones_q == ONES_W'(1)) begin
            tot_q   <= TOT_W'(2);
            state_q <= ST_TYPE;
          end else begin
            fld_left_q <= ones_q;
            fld_q      <= '0;
            state_q    <= ST_CNT;
          end
        end
        ST_CNT: if (accept) begin
          fld_q      <= fld_next;
          fld_left_q <= fld_left_q - ONES_W'(1);
          if (fld_left_q == ONES_W'(1)) begin
            tot_q   <= tot_from_fld;
            state_q <= ST_TYPE;
          end
        end
        ST_TYPE: if (accept) begin
          idx_q   <= '0;
          state_q <= in_bit ? ST_FILLV : ST_LIT;
        end
        ST_FILLV: if (accept) begin
          fill_mode_q <= 1'b1;
          idx_q       <= IDX_W'(1);
          state_q     <= ST_EMIT;
        end
        ST_LIT: if (accept) begin
          if (last_idx) begin
            idx_q <= '0;
            if (tot_q == TOT_W'(1)) begin
              ones_q  <= '0;
              state_q <= ST_PFX;
            end else begin
              tot_q       <= tot_q - TOT_W'(1);
              fill_mode_q <= 1'b0;
              state_q     <= ST_EMIT;
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_EMIT: begin
          if (last_idx) begin
            idx_q <= '0;
            if (tot_q == TOT_W'(1)) begin
              ones_q  <= '0;
              state_q <= ST_PFX;
            end else begin
              tot_q <= tot_q - TOT_W'(1);
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign state_o = state_q;

endmodule

// File: rtl/bm_decomp.sv
module bm_decomp #(
  parameter int MIN_BLK  = 4,
  parameter int MAX_BLK  = 10,
  parameter int HDR_W    = 3,
  parameter int MAX_ONES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  output logic out_bit,
  output logic out_valid
);
  import bm_pkg::*;

  localparam int IDX_W = $clog2(MAX_BLK);

  logic             emit_en;
  logic             emit_bit;
  bm_src_e          emit_src;
  logic             wr_en;
  logic             fill_ld;
  logic [IDX_W-1:0] idx;
  bm_state_e        ctl_state;

  bm_ctrl #(
    .MIN_BLK  (MIN_BLK),
    .MAX_BLK  (MAX_BLK),
    .HDR_W    (HDR_W),
    .MAX_ONES (MAX_ONES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_bit   (in_bit),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .emit_en  (emit_en),
    .emit_src (emit_src),
    .wr_en    (wr_en),
    .fill_ld  (fill_ld),
    .idx_o    (idx),
    .state_o  (ctl_state)
  );

  bm_blk_store #(
    .MAX_BLK (MAX_BLK)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .idx     (idx),
    .in_bit  (in_bit),
    .fill_ld (fill_ld),
    .src     (emit_src),
    .data_o  (emit_bit)
  );

  bm_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .emit_en   (emit_en),
    .emit_bit  (emit_bit),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/bm_decomp_chk.sv
module bm_decomp_chk (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              in_bit,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_bit,
  input logic              out_valid,
  input bm_pkg::bm_state_e ctl_state
);
  import bm_pkg::*;

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RST_IDLE: assert (ctl_state == ST_IDLE && !out_valid && !in_ready); // R1
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ctl_state == ST_IDLE && !start) |=> (ctl_state == ST_IDLE && !out_valid)); // R2

  AST_START_TO_HDR: assert property (@(posedge clk) disable iff (rst)
    start |=> (ctl_state == ST_HDR)); // R2

  AST_LIT_PASSES: assert property (@(posedge clk) disable iff (rst)
    (ctl_state == ST_LIT && in_ready && in_valid && !start)
      |=> (out_valid && out_bit == $past(in_bit))); // R4

  AST_REPLAY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (ctl_state == ST_EMIT) |-> !in_ready); // R8

  AST_REPLAY_STREAMS: assert property (@(posedge clk) disable iff (rst)
    (ctl_state == ST_EMIT && !start) |=> out_valid); // R8

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid); // R9

endmodule

bind bm_decomp bm_decomp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .in_bit    (in_bit),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_bit   (out_bit),
  .out_valid (out_valid),
  .ctl_state (ctl_state)
);

// File: tb/bm_decomp_tb_top.sv
module bm_decomp_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic out_bit;
  logic out_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int first_out = -1;
  int last_out = -1;

  bit enc_q[$];
  bit exp_q[$];
  bit got_q[$];

  bm_decomp dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_bit    (in_bit),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_q.push_back(out_bit);
      if (first_out < 0) first_out = cyc;
      last_out = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc >= 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_val(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) enc_q.push_back(bit'((v >> i) & 1));
  endtask

  // codeword builder and expected expansion from the requirements
  task automatic add_cw(input int b, input int total, input bit is_fill,
                        input bit fv, input logic [9:0] data);
    int k;
    if (total == 1) begin
      enc_q.push_back(1'b0);
      for (int i = 0; i < b; i++) begin
        enc_q.push_back(data[i]);
        exp_q.push_back(data[i]);
      end
      return;
    end
    if (total == 2) begin
      enc_q.push_back(1'b1);
      enc_q.push_back(1'b0);
    end else begin
      k = 2;
      while (total > 2 * ((1 << k) - 1)) k++;
      for (int i = 0; i < k; i++) enc_q.push_back(1'b1);
      if (k < 5) enc_q.push_back(1'b0);
      push_val(total - ((1 << k) - 1), k);
    end
    if (is_fill) begin
      enc_q.push_back(1'b1);
      enc_q.push_back(fv);
      for (int i = 0; i < total * b; i++) exp_q.push_back(fv);
    end else begin
      enc_q.push_back(1'b0);
      for (int i = 0; i < b; i++) enc_q.push_back(data[i]);
      for (int c = 0; c < total; c++)
        for (int i = 0; i < b; i++) exp_q.push_back(data[i]);
    end
  endtask

  task automatic feed(input int stall_pct, input bit do_start);
    if (do_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    foreach (enc_q[n]) begin
      forever begin
        @(negedge clk);
        in_bit   = enc_q[n];
        in_valid = ($urandom_range(99) >= stall_pct);
        if (in_valid && in_ready) break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    enc_q.delete();
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 30) begin
      @(negedge clk);
      if (out_valid || !in_ready) idle = 0;
      else idle++;
    end
  endtask

  task automatic compare(input string req);
    int bad = -1;
    int n;
    chk(got_q.size() == exp_q.size(), req, "output length", got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    end
    if (bad >= 0)
      chk(1'b0, req, $sformatf("bit %0d", bad), got_q[bad], exp_q[bad]);
    else
      chk(1'b1, req, "bits", 0, 0);
    got_q.delete();
    exp_q.delete();
    first_out = -1;
    last_out = -1;
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R2: bits offered before start are ignored
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (6) @(negedge clk);
    chk(in_ready == 1'b0, "R2", "in_ready while idle", in_ready, 0);
    chk(got_q.size() == 0, "R2", "outputs while idle", got_q.size(), 0);
    in_valid = 1'b0;

    // R11: worked vector, block length 5
    push_val(1, 3);
    push_val(3'b110, 3); push_val(2'b01, 2); enc_q.push_back(1'b0); push_val(5'b10111, 5);
    push_val(4'b1010, 4);
    enc_q.push_back(1'b0); push_val(5'b11000, 5);
    for (int c = 0; c < 4; c++)
      for (int i = 4; i >= 0; i--) exp_q.push_back(bit'((5'b10111 >> i) & 1));
    for (int i = 0; i < 10; i++) exp_q.push_back(1'b0);
    for (int i = 4; i >= 0; i--) exp_q.push_back(bit'((5'b11000 >> i) & 1));
    feed(0, 1'b1); drain(); compare("R11");

    // R8: five copies of a 4-bit literal come out as one contiguous run
    push_val(0, 3);
    add_cw(4, 5, 1'b0, 1'b0, 10'b1101);
    feed(0, 1'b1); drain();
    chk(last_out - first_out + 1 == 20, "R8", "span of contiguous output",
        last_out - first_out + 1, 20);
    compare("R8");

    // R3: header 111 gives length 10; R4 single literal block
    push_val(7, 3);
    add_cw(10, 1, 1'b0, 1'b0, 10'b1001110101);
    feed(0, 1'b1); drain(); compare("R3 R4");

    // R6 R7: largest group, 62 fill copies and 31 literal copies
    push_val(0, 3);
    add_cw(4, 62, 1'b1, 1'b1, 10'b0);
    add_cw(4, 31, 1'b0, 1'b0, 10'b0110);
    add_cw(4, 2, 1'b1, 1'b0, 10'b0);
    feed(10, 1'b1); drain(); compare("R6 R7 R5");

    // R2: start in the middle of a codeword restarts at the header
    push_val(0, 3);
    push_val(4'b1100, 4);
    feed(0, 1'b1);
    push_val(2, 3);
    add_cw(6, 3, 1'b1, 1'b1, 10'b0);
    add_cw(6, 2, 1'b0, 1'b0, 10'b101100);
    feed(0, 1'b1); drain(); compare("R2 R5");

    // R5 R6 R7 R9 R10: random streams with tester stalls
    for (int s = 0; s < 20; s++) begin
      int b;
      int ncw;
      b = $urandom_range(10, 4);
      push_val(b - 4, 3);
      ncw = $urandom_range(6, 1);
      for (int c = 0; c < ncw; c++) begin
        int g;
        int total;
        g = $urandom_range(5, 0);
        if (g == 0) total = 1;
        else if (g == 1) total = 2;
        else total = $urandom_range(2 * ((1 << g) - 1), (1 << g) - 1);
        add_cw(b, total, bit'($urandom_range(1)), bit'($urandom_range(1)),
               10'($urandom));
      end
      feed($urandom_range(40, 0), 1'b1);
      drain();
      compare("R5 R6 R7 R9 R10");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule